// File: doc/BRIEF.md
# Pre-Trigger Capture Controller

This block sequences the writing of sample data into a capture memory. Software arms it with a single-cycle strobe; from then on every valid sample is written to the next location of a circular window whose length is programmable, so the memory always holds the most recent history. A qualified trigger then switches the block to counting a programmed number of post-trigger samples. When that count is reached the block stops writing, raises a done flag, and keeps the address of the first post-trigger sample, so software can unroll the history.

The trigger source is chosen by a select bit. The external source is an asynchronous level that is synchronised and edge-detected. It counts only if it is still high at the first sample strobe after its rising edge has been seen. The internal source is a software trigger bit. Writes to it are accepted only while the block is waiting for a trigger, the acquisition-enable bit is set and the internal source is selected. The bit clears itself when the trigger it requested is taken.

States: `ST_IDLE` (after reset, no writes), `ST_PRESTORE` (circular filling, waiting for a trigger), `ST_POST` (counting post-trigger samples), `ST_DONE` (capture finished, no writes). Transitions:
- **arm** goes from any state to `ST_PRESTORE`.
- **trigger** goes from `ST_PRESTORE` to `ST_POST`, or straight to `ST_DONE` when the post count is at most 1.
- **count reached** goes from `ST_POST` to `ST_DONE`.

Top module: `ptcap_ctrl`

## Requirements
- R1: After reset, `wr_en`, `cap_done` and `sw_trig_bit` are 0, `wr_addr` and `trig_addr` are 0, and a sample strobe is not written.
- R2: A pulse on `arm_wr` in any state sets the write pointer to 0, clears `cap_done` and `trig_addr`, and starts circular filling from the next cycle.
- R3: While filling or counting post-trigger samples, each `smp_vld` cycle gives `wr_en`=1 with `wr_addr` equal to the current pointer, and the pointer then advances by one.
- R4: The pointer wraps from `buf_len`-1 to 0, where `buf_len` is a value from 2 to 2^AW.
- R5: `trig_sel`=1 selects the software trigger and `trig_sel`=0 selects `ext_trig`. The source that is not selected has no effect.
- R6: `ext_trig` passes through two synchroniser flops and is edge-detected. A rising edge is accepted only if the synchronised level is still high at the first `smp_vld` after the edge is registered. A level that is already high at arming does not trigger.
- R7: A `sw_trig_wr` pulse sets `sw_trig_bit` only while filling with `acq_en`=1 and `trig_sel`=1. Otherwise the write is ignored.
- R8: `sw_trig_bit` clears itself on the sample strobe that accepts the software trigger.
- R9: The strobe that accepts a trigger is written as the first post-trigger sample, and `trig_addr` takes its address. After `post_cnt` post-trigger samples (at least one), `cap_done` rises on the next cycle and no further writes occur.
- R10: Triggers that arrive before arming or while done are ignored. `cap_done` and `trig_addr` hold until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_wr | input | 1 | One-cycle arm strobe |
| trig_sel | input | 1 | 1 = software trigger, 0 = external trigger |
| acq_en | input | 1 | Acquisition enable, qualifies the software trigger |
| sw_trig_wr | input | 1 | Write strobe that requests the software trigger |
| ext_trig | input | 1 | Asynchronous external trigger level |
| smp_vld | input | 1 | A sample is available this cycle |
| buf_len | input | AW+1 | Circular window length in samples |
| post_cnt | input | CW | Number of post-trigger samples |
| wr_addr | output | AW | Memory write address |
| wr_en | output | 1 | Memory write enable |
| cap_done | output | 1 | Capture complete |
| trig_addr | output | AW | Address of the first post-trigger sample |
| sw_trig_bit | output | 1 | Readback of the self-clearing software trigger bit |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- **Pointer wrap.** Windows of 2, 3 and 5 entries, and pre-trigger runs longer than the window, catch a pointer that wraps one early or one late. Such a pointer gives a wrong trigger or final address.
- **Synchroniser latency.** Samples are issued while an external edge is still in the synchroniser. A design with the wrong latency would mark one of those samples as the trigger sample.
- **Short external pulse.** A pulse that has gone low before the next strobe must not trigger. A design without the second check would start a capture here.
- **Ignored triggers.** Software writes are issued in idle, with enable low, with the external source selected, and after done. Any of them latching or starting a capture would show on `sw_trig_bit`, `cap_done` or `trig_addr`.
- **Stopping after done.** Extra strobes after done catch a design that keeps writing and corrupts the captured history.

// File: rtl/ptcap_pkg.sv
package ptcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PRESTORE = 2'd1,
        ST_POST     = 2'd2,
        ST_DONE     = 2'd3
    } cap_state_e;

    localparam logic TSEL_EXT = 1'b0;
    localparam logic TSEL_INT = 1'b1;

endpackage

// File: rtl/ptcap_trig_qual.sv
module ptcap_trig_qual
    import ptcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic listen,
    input  logic trig_sel,
    input  logic acq_en,
    input  logic sw_wr,
    input  logic smp_vld,
    input  logic ext_trig,
    output logic trig_hit,
    output logic sw_bit
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic ext_s;
    logic ext_prev_q;
    logic ext_rise;
    logic ext_pend_q;
    logic ext_pend_d;
    logic sw_q;
    logic sw_d;
    logic hit_ext;
    logic hit_sw;

    // synchroniser chain, length chosen by parameter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= ext_trig;
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign ext_s    = sync_q[LAST];
    assign ext_rise = ext_s & ~ext_prev_q;

    always_comb begin
        if (!listen || trig_sel != TSEL_EXT) begin
            ext_pend_d = 1'b0;
        end else if (ext_rise) begin
            ext_pend_d = 1'b1;
        end else if (smp_vld) begin
            ext_pend_d = 1'b0;
        end else begin
            ext_pend_d = ext_pend_q;
        end
    end

    assign hit_ext = listen && (trig_sel == TSEL_EXT) && ext_pend_q && smp_vld && ext_s;
    assign hit_sw  = listen && (trig_sel == TSEL_INT) && acq_en && sw_q && smp_vld;

    always_comb begin
        if (!listen || hit_sw) begin
            sw_d = 1'b0;
        end else if (sw_wr && acq_en && (trig_sel == TSEL_INT)) begin
            sw_d = 1'b1;
        end else begin
            sw_d = sw_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev_q <= 1'b0;
            ext_pend_q <= 1'b0;
            sw_q       <= 1'b0;
        end else begin
            ext_prev_q <= ext_s;
            ext_pend_q <= ext_pend_d;
            sw_q       <= sw_d;
        end
    end

    assign trig_hit = hit_ext | hit_sw;
    assign sw_bit   = sw_q;

    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sw |=> !sw_q);  // R8
    AST_SW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_q) |-> $past(acq_en && (trig_sel == TSEL_INT) && listen));  // R7
    AST_EXT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ext |-> $past(ext_pend_d));  // R6

endmodule

// File: rtl/ptcap_wptr.sv
module ptcap_wptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [AW:0]   len,
    output logic [AW-1:0] ptr
);

    logic [AW:0] ptr_plus;
    logic        at_end;

    assign ptr_plus = {1'b0, ptr} + 1'b1;
    assign at_end   = (ptr_plus >= len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= at_end ? '0 : ptr_plus[AW-1:0];
        end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && ({1'b0, ptr} == len - 1'b1)) |=> (ptr == '0));  // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && ({1'b0, ptr} + 1'b1 < len)) |=> (ptr == $past(ptr) + 1'b1));  // R3

endmodule

// File: rtl/ptcap_seq.sv
module ptcap_seq
    import ptcap_pkg::*;
#(
    parameter int AW = 10,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_wr,
    input  logic          smp_vld,
    input  logic          trig_hit,
    input  logic [CW-1:0] post_cnt,
    input  logic [AW-1:0] ptr,
    output logic          listen,
    output logic          wr_en,
    output logic          cap_done,
    output logic [AW-1:0] trig_addr
);

    cap_state_e state_q;
    cap_state_e state_d;
    logic [CW:0] cnt_q;
    logic [CW:0] cnt_plus;
    logic        short_post;

    assign cnt_plus   = cnt_q + 1'b1;
    assign short_post = ({1'b0, post_cnt} <= 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (arm_wr) begin
            state_d = ST_PRESTORE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_PRESTORE: if (trig_hit) state_d = short_post ? ST_DONE : ST_POST;
                ST_POST:     if (smp_vld && cnt_plus >= {1'b0, post_cnt}) state_d = ST_DONE;
                ST_DONE:     state_d = ST_DONE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        cap_done = 1'b0;
        listen   = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_PRESTORE: begin
                wr_en  = smp_vld && !arm_wr;
                listen = !arm_wr;
            end
            ST_POST:     wr_en = smp_vld && !arm_wr;
            ST_DONE:     cap_done = 1'b1;
            default:     ;
        endcase
    end

    // post-trigger counter and trigger address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            trig_addr <= '0;
        end else if (arm_wr) begin
            cnt_q     <= '0;
            trig_addr <= '0;
        end else if (state_q == ST_PRESTORE && trig_hit) begin
            cnt_q     <= {{CW{1'b0}}, 1'b1};
            trig_addr <= ptr;
        end else if (state_q == ST_POST && smp_vld) begin
            cnt_q     <= cnt_plus;
        end
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && !arm_wr) |=> cap_done);  // R10
    AST_TADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && $past(cap_done) && !$past(arm_wr)) |-> $stable(trig_addr));  // R10
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_done) |-> $past(wr_en));  // R9

endmodule

// File: rtl/ptcap_ctrl.sv
module ptcap_ctrl
    import ptcap_pkg::*;
#(
    parameter int AW = 10,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_wr,
    input  logic          trig_sel,
    input  logic          acq_en,
    input  logic          sw_trig_wr,
    input  logic          ext_trig,
    input  logic          smp_vld,
    input  logic [AW:0]   buf_len,
    input  logic [CW-1:0] post_cnt,
    output logic [AW-1:0] wr_addr,
    output logic          wr_en,
    output logic          cap_done,
    output logic [AW-1:0] trig_addr,
    output logic          sw_trig_bit
);

    logic listen;
    logic trig_hit;

    ptcap_trig_qual #(.SYNC_STAGES(2)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .listen   (listen),
        .trig_sel (trig_sel),
        .acq_en   (acq_en),
        .sw_wr    (sw_trig_wr),
        .smp_vld  (smp_vld),
        .ext_trig (ext_trig),
        .trig_hit (trig_hit),
        .sw_bit   (sw_trig_bit)
    );

    ptcap_wptr #(.AW(AW)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm_wr),
        .inc   (wr_en),
        .len   (buf_len),
        .ptr   (wr_addr)
    );

    ptcap_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_wr    (arm_wr),
        .smp_vld   (smp_vld),
        .trig_hit  (trig_hit),
        .post_cnt  (post_cnt),
        .ptr       (wr_addr),
        .listen    (listen),
        .wr_en     (wr_en),
        .cap_done  (cap_done),
        .trig_addr (trig_addr)
    );

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (wr_addr == '0 && !cap_done));  // R2
    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < buf_len));  // R4
    AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && $past(cap_done)) |-> !wr_en);  // R9

endmodule

// File: tb/ptcap_ctrl_tb.sv
module ptcap_ctrl_tb;

    localparam int AW = 10;
    localparam int CW = 12;
    localparam time CLK_PERIOD = 10ns;

    // len, post, pre, expected trig_addr, expected final wr_addr
    localparam int NVEC = 6;
    localparam int VEC [0:NVEC-1][0:4] = '{
        '{8,  4, 3,  3, 7},
        '{8,  4, 10, 2, 6},
        '{5,  3, 7,  2, 0},
        '{16, 1, 0,  0, 1},
        '{3,  5, 4,  1, 0},
        '{2,  2, 1,  1, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_wr = 1'b0;
    logic          trig_sel = 1'b1;
    logic          acq_en = 1'b0;
    logic          sw_trig_wr = 1'b0;
    logic          ext_trig = 1'b0;
    logic          smp_vld = 1'b0;
    logic [AW:0]   buf_len = 11'd8;
    logic [CW-1:0] post_cnt = 12'd1;
    logic [AW-1:0] wr_addr;
    logic          wr_en;
    logic          cap_done;
    logic [AW-1:0] trig_addr;
    logic          sw_trig_bit;

    int errors = 0;
    int checks = 0;
    int m_ptr  = 0;
    int m_len  = 8;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptcap_ctrl #(.AW(AW), .CW(CW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_wr      (arm_wr),
        .trig_sel    (trig_sel),
        .acq_en      (acq_en),
        .sw_trig_wr  (sw_trig_wr),
        .ext_trig    (ext_trig),
        .smp_vld     (smp_vld),
        .buf_len     (buf_len),
        .post_cnt    (post_cnt),
        .wr_addr     (wr_addr),
        .wr_en       (wr_en),
        .cap_done    (cap_done),
        .trig_addr   (trig_addr),
        .sw_trig_bit (sw_trig_bit)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one sample strobe, starting and ending at a falling edge
    task automatic smp(input bit exp_wr, input string rq);
        smp_vld = 1'b1;
        #1;
        chk(wr_en == exp_wr, rq, int'(wr_en), int'(exp_wr));
        if (exp_wr) chk(int'(wr_addr) == m_ptr, rq, int'(wr_addr), m_ptr);
        @(negedge clk);
        smp_vld = 1'b0;
        if (exp_wr) m_ptr = (m_ptr + 1) % m_len;
    endtask

    task automatic arm(input int len, input int post);
        buf_len  = (AW+1)'(len);
        post_cnt = CW'(post);
        m_len    = len;
        arm_wr   = 1'b1;
        @(negedge clk);
        arm_wr   = 1'b0;
        m_ptr    = 0;
    endtask

    task automatic sw_fire();
        sw_trig_wr = 1'b1;
        @(negedge clk);
        sw_trig_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, no writes in idle
        chk(wr_en == 1'b0, "R1", int'(wr_en), 0);
        chk(cap_done == 1'b0, "R1", int'(cap_done), 0);
        chk(wr_addr == '0, "R1", int'(wr_addr), 0);
        chk(trig_addr == '0, "R1", int'(trig_addr), 0);
        chk(sw_trig_bit == 1'b0, "R1", int'(sw_trig_bit), 0);
        smp(1'b0, "R1");

        // R10/R7: software trigger before arming is dropped
        acq_en = 1'b1; trig_sel = 1'b1;
        sw_fire();
        chk(sw_trig_bit == 1'b0, "R10", int'(sw_trig_bit), 0);

        // R6/R10: external level already high at arm does not trigger
        trig_sel = 1'b0;
        ext_trig = 1'b1;
        idle(4);
        arm(8, 2);
        for (int i = 0; i < 6; i++) smp(1'b1, "R6");
        chk(cap_done == 1'b0, "R6", int'(cap_done), 0);
        ext_trig = 1'b0;
        idle(3);

        // table-driven software-trigger captures (R3, R4, R8, R9)
        for (int v = 0; v < NVEC; v++) begin
            acq_en = 1'b1; trig_sel = 1'b1;
            arm(VEC[v][0], VEC[v][1]);
            chk(cap_done == 1'b0, "R2", int'(cap_done), 0);
            chk(wr_addr == '0, "R2", int'(wr_addr), 0);
            for (int k = 0; k < VEC[v][2]; k++) smp(1'b1, "R3");
            sw_fire();
            chk(sw_trig_bit == 1'b1, "R7", int'(sw_trig_bit), 1);
            for (int k = 0; k < VEC[v][1]; k++) begin
                chk(cap_done == 1'b0, "R9", int'(cap_done), 0);
                smp(1'b1, "R3");
                if (k == 0) chk(sw_trig_bit == 1'b0, "R8", int'(sw_trig_bit), 0);
            end
            chk(cap_done == 1'b1, "R9", int'(cap_done), 1);
            chk(int'(trig_addr) == VEC[v][3], "R9", int'(trig_addr), VEC[v][3]);
            chk(int'(wr_addr) == VEC[v][4], "R4", int'(wr_addr), VEC[v][4]);
            smp(1'b0, "R9");
        end

        // R7: software write ignored with enable low
        acq_en = 1'b0; trig_sel = 1'b1;
        arm(8, 2);
        sw_fire();
        chk(sw_trig_bit == 1'b0, "R7", int'(sw_trig_bit), 0);
        // R5: software write ignored with external source selected
        acq_en = 1'b1; trig_sel = 1'b0;
        sw_fire();
        chk(sw_trig_bit == 1'b0, "R5", int'(sw_trig_bit), 0);
        for (int i = 0; i < 4; i++) smp(1'b1, "R5");
        chk(cap_done == 1'b0, "R5", int'(cap_done), 0);

        // R5: external edge ignored with internal source selected
        trig_sel = 1'b1;
        arm(8, 2);
        ext_trig = 1'b1;
        idle(4);
        for (int i = 0; i < 6; i++) smp(1'b1, "R5");
        chk(cap_done == 1'b0, "R5", int'(cap_done), 0);
        ext_trig = 1'b0;
        idle(3);

        // R6: short external pulse, low again before the next strobe
        trig_sel = 1'b0;
        arm(8, 2);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        idle(5);
        for (int i = 0; i < 4; i++) smp(1'b1, "R6");
        chk(cap_done == 1'b0, "R6", int'(cap_done), 0);

        // R6: valid external trigger; samples during synchroniser latency are pre-trigger
        arm(8, 3);
        smp(1'b1, "R3");
        smp(1'b1, "R3");
        ext_trig = 1'b1;
        for (int i = 0; i < 3; i++) begin
            smp(1'b1, "R6");
            chk(cap_done == 1'b0, "R6", int'(cap_done), 0);
        end
        for (int i = 0; i < 3; i++) smp(1'b1, "R6");
        chk(cap_done == 1'b1, "R6", int'(cap_done), 1);
        chk(trig_addr == 10'd5, "R6", int'(trig_addr), 5);
        chk(wr_addr == 10'd0, "R4", int'(wr_addr), 0);
        ext_trig = 1'b0;
        idle(3);

        // R10: triggers after done are ignored, state is held
        trig_sel = 1'b1; acq_en = 1'b1;
        sw_fire();
        chk(sw_trig_bit == 1'b0, "R10", int'(sw_trig_bit), 0);
        trig_sel = 1'b0;
        ext_trig = 1'b1;
        idle(4);
        smp(1'b0, "R10");
        smp(1'b0, "R10");
        chk(cap_done == 1'b1, "R10", int'(cap_done), 1);
        chk(trig_addr == 10'd5, "R10", int'(trig_addr), 5);
        ext_trig = 1'b0;
        idle(3);

        // R2: re-arm from done
        arm(8, 2);
        chk(cap_done == 1'b0, "R2", int'(cap_done), 0);
        chk(wr_addr == '0, "R2", int'(wr_addr), 0);
        chk(trig_addr == '0, "R2", int'(trig_addr), 0);
        smp(1'b1, "R2");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule